// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames and can run in a multi-drop mode. In that mode every frame carries one extra flag bit after its eight data bits. A flag of 1 marks the frame as a station identifier. A flag of 0 marks it as ordinary payload. Software sets a filter control bit when the payload on the line is meant for another station. While the filter is set, payload frames pass without any effect: no data is stored, no flag changes and no interrupt is raised. The first identifier frame that arrives is stored normally, and the hardware clears the filter bit so that the frames after it are received.

The line is oversampled by a tick that runs at sixteen times the bit rate. A falling edge is confirmed at mid-bit before the receiver starts to assemble a frame. Each bit after that is sampled at the centre of its sixteen ticks. Software clears the receive-full flag and the error flags with single-cycle strobes. The receive interrupt request and the error interrupt request are level outputs gated by an enable input.

Top module: `mpuart_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits with the least significant bit first, a flag bit only when `mp_en`=1, and a stop bit. An accepted frame whose `rx_full` is 0 loads `rx_data` and sets `rx_full` to 1. When `mp_en`=1, it also copies the flag bit into `mpb_flag`.
- R2: While `filt_en`=1, `mp_en`=1 and `sync_mode`=0, a frame with flag bit 0 is discarded. `rx_data`, `rx_full`, `frm_err`, `ovr_err` and `mpb_flag` all keep their values, even when that frame's stop bit is bad.
- R3: A frame with flag bit 1 received while `mp_en`=1 sets `mpb_flag` to 1, clears `filt_en` to 0 and is accepted as in R1.
- R4: After the filter has cleared, frames with flag bit 0 are accepted again and set `mpb_flag` to 0.
- R5: When `mp_en`=0 or `sync_mode`=1, `filt_en`=1 has no effect and every frame is accepted. A frame with flag 0 received while `mp_en`=1 and `sync_mode`=1 leaves `filt_en` at 1.
- R6: `filt_en` resets to 0. A `filt_wr` strobe loads `filt_en` from `filt_wdata`, so writing 0 ends filtering.
- R7: `irq_rx` equals `rie` AND `rx_full`, and `irq_err` equals `rie` AND (`frm_err` OR `ovr_err`). Both are forced to 0 while the filter of R2 is active.
- R8: An accepted frame whose stop bit is sampled 0 sets `frm_err` to 1.
- R9: An accepted frame that completes while `rx_full`=1 sets `ovr_err` to 1 and leaves `rx_data` unchanged.
- R10: A `clr_full` strobe clears `rx_full`. A strobe while `rx_full`=0 changes no output. A `clr_err` strobe clears `frm_err` and `ovr_err`.
- R11: A low pulse on `rxd` shorter than half a bit returns the receiver to idle and stores nothing.
- R12: After reset, `rx_data`=0 and `rx_full`, `frm_err`, `ovr_err`, `mpb_flag`, `filt_en`, `irq_rx` and `irq_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle pulse at sixteen times the bit rate |
| mp_en | input | 1 | Multi-drop frame format (adds flag bit) |
| sync_mode | input | 1 | Synchronous-mode select; disables the filter |
| rie | input | 1 | Receive and error interrupt enable |
| filt_wr | input | 1 | Write strobe for the filter bit |
| filt_wdata | input | 1 | Value written to the filter bit |
| clr_full | input | 1 | Clear strobe for rx_full |
| clr_err | input | 1 | Clear strobe for frm_err and ovr_err |
| rx_data | output | 8 | Received data register |
| rx_full | output | 1 | Receive data register holds unread data |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun flag |
| mpb_flag | output | 1 | Flag bit of the last accepted multi-drop frame |
| filt_en | output | 1 | Filter bit, cleared by hardware on identifier frames |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
A filter bit stuck at 1 shows up in `filt_en` one clock after an identifier frame completes. An accept decision that ignores the flag bit shows up as a changed `rx_data` or `rx_full` within a clock of a discarded frame's stop-bit sample. A bit counter or mid-bit offset that is off by one shifts or corrupts `rx_data` on the first frame. A start check that does not return to idle turns a glitch into a stored frame within one frame time. An error in the interrupt gating shows at once on `irq_rx` or `irq_err` when the filter is armed while `rx_full` is set.

// File: rtl/mpuart_pkg.sv
// Shared types for the address-filtering serial receiver.
package mpuart_pkg;
    // Receive sequencer states.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_FLAG,
        RX_STOP
    } rx_state_t;
endpackage

// File: rtl/mpuart_framer.sv
// Frame assembler: confirms a start bit at mid-bit, samples each later bit
// at the centre of its OVS ticks and pulses done for one clock once the stop
// bit has been sampled.
// Assumes: rxd_s is already synchronised; tick is a one-clock pulse.
module mpuart_framer
    import mpuart_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd_s,
    input  logic          tick,
    input  logic          mp_en,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          flag_bit,
    output logic          stop_ok
);
    localparam int CW  = $clog2(OVS);
    localparam int IW  = (DW > 1) ? $clog2(DW) : 1;
    localparam int MID = OVS / 2;

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;

    // Sequencer: tick counting, bit sampling and the frame-complete strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            cnt      <= '0;
            idx      <= '0;
            data     <= '0;
            flag_bit <= 1'b0;
            stop_ok  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rxd_s) begin
                            state <= RX_START;
                            cnt   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CW'(MID - 1)) begin
                            cnt      <= '0;
                            idx      <= '0;
                            flag_bit <= 1'b0;
                            state    <= rxd_s ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt  <= '0;
                            data <= {rxd_s, data[DW-1:1]};
                            if (idx == IW'(DW - 1)) begin
                                state <= mp_en ? RX_FLAG : RX_STOP;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_FLAG: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt      <= '0;
                            flag_bit <= rxd_s;
                            state    <= RX_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CW'(OVS - 1)) begin
                            cnt     <= '0;
                            stop_ok <= rxd_s;
                            done    <= 1'b1;
                            state   <= RX_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpuart_flags.sv
// Receive register, status flags, filter bit and interrupt gating.
// Assumes: done is a single-cycle pulse with data, flag_in and stop_in valid.
module mpuart_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] data_in,
    input  logic          flag_in,
    input  logic          stop_in,
    input  logic          mp_en,
    input  logic          sync_mode,
    input  logic          rie,
    input  logic          filt_wr,
    input  logic          filt_wdata,
    input  logic          clr_full,
    input  logic          clr_err,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          frm_err,
    output logic          ovr_err,
    output logic          mpb_flag,
    output logic          filt_en,
    output logic          irq_rx,
    output logic          irq_err
);
    logic filt_act;
    logic accept;
    logic id_hit;

    // Decode whether the filter is in force and whether the frame counts.
    always_comb begin
        filt_act = filt_en & mp_en & ~sync_mode;
        accept   = done & ~(filt_act & ~flag_in);
        id_hit   = done & mp_en & flag_in;
    end

    // Filter bit: software write has priority over the hardware clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_en <= 1'b0;
        end else if (filt_wr) begin
            filt_en <= filt_wdata;
        end else if (id_hit) begin
            filt_en <= 1'b0;
        end
    end

    // Data register and flags: clear strobes first, frame updates after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_full  <= 1'b0;
            frm_err  <= 1'b0;
            ovr_err  <= 1'b0;
            mpb_flag <= 1'b0;
        end else begin
            if (clr_full) rx_full <= 1'b0;
            if (clr_err) begin
                frm_err <= 1'b0;
                ovr_err <= 1'b0;
            end
            if (accept) begin
                if (rx_full) begin
                    ovr_err <= 1'b1;
                end else begin
                    rx_data <= data_in;
                    rx_full <= 1'b1;
                end
                if (!stop_in) frm_err <= 1'b1;
                if (mp_en) mpb_flag <= flag_in;
            end
        end
    end

    // Interrupt requests, held off while the filter is active.
    always_comb begin
        irq_rx  = rie & rx_full & ~filt_act;
        irq_err = rie & (frm_err | ovr_err) & ~filt_act;
    end
endmodule

// File: rtl/mpuart_rx.sv
// Address-filtering serial receiver top: synchronises the line, assembles
// frames and keeps the receive register, flags and filter bit.
// Assumes: tick16 runs at OVS times the bit rate; controls are synchronous.
module mpuart_rx #(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          tick16,
    input  logic          mp_en,
    input  logic          sync_mode,
    input  logic          rie,
    input  logic          filt_wr,
    input  logic          filt_wdata,
    input  logic          clr_full,
    input  logic          clr_err,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          frm_err,
    output logic          ovr_err,
    output logic          mpb_flag,
    output logic          filt_en,
    output logic          irq_rx,
    output logic          irq_err
);
    logic [1:0]    rxd_sync;
    logic          fr_done;
    logic [DW-1:0] fr_data;
    logic          fr_mpb;
    logic          fr_stop;

    // Two-stage synchroniser for the asynchronous line, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_sync <= 2'b11;
        else        rxd_sync <= {rxd_sync[0], rxd};
    end

    mpuart_framer #(.OVS(OVS), .DW(DW)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd_s    (rxd_sync[1]),
        .tick     (tick16),
        .mp_en    (mp_en),
        .done     (fr_done),
        .data     (fr_data),
        .flag_bit (fr_mpb),
        .stop_ok  (fr_stop)
    );

    mpuart_flags #(.DW(DW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (fr_done),
        .data_in    (fr_data),
        .flag_in    (fr_mpb),
        .stop_in    (fr_stop),
        .mp_en      (mp_en),
        .sync_mode  (sync_mode),
        .rie        (rie),
        .filt_wr    (filt_wr),
        .filt_wdata (filt_wdata),
        .clr_full   (clr_full),
        .clr_err    (clr_err),
        .rx_data    (rx_data),
        .rx_full    (rx_full),
        .frm_err    (frm_err),
        .ovr_err    (ovr_err),
        .mpb_flag   (mpb_flag),
        .filt_en    (filt_en),
        .irq_rx     (irq_rx),
        .irq_err    (irq_err)
    );
endmodule

// File: rtl/mpuart_rx_chk.sv
// Property checker for mpuart_rx, attached by bind below.
module mpuart_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fr_done,
    input logic          fr_mpb,
    input logic          mp_en,
    input logic          sync_mode,
    input logic          rie,
    input logic          filt_wr,
    input logic          filt_en,
    input logic          clr_full,
    input logic          clr_err,
    input logic [DW-1:0] rx_data,
    input logic          rx_full,
    input logic          frm_err,
    input logic          ovr_err,
    input logic          mpb_flag,
    input logic          irq_rx,
    input logic          irq_err
);
    logic filt_on;
    assign filt_on = filt_en & mp_en & ~sync_mode;

    // R2: a discarded payload frame leaves the register and flags alone.
    p_discard_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && filt_on && !fr_mpb && !clr_full && !clr_err)
        |=> ($stable(rx_data) && $stable(rx_full) && $stable(frm_err)
             && $stable(ovr_err) && $stable(mpb_flag)));

    // R3: an identifier frame drops the filter and raises the flag.
    p_id_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && mp_en && fr_mpb && !filt_wr) |=> (!filt_en && mpb_flag));

    // R7: no interrupt request while the filter is in force.
    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        filt_on |-> (!irq_rx && !irq_err));

    // R7: requests only with the enable set.
    p_irq_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx || irq_err) |-> rie);

    // R9: an accepted frame onto a full register flags overrun, keeps data.
    p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_done && rx_full && !clr_full && !(filt_on && !fr_mpb))
        |=> (ovr_err && $stable(rx_data)));

    // R10: the clear strobe empties the register when no frame lands.
    p_clear_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_full && !fr_done) |=> !rx_full);
endmodule

bind mpuart_rx mpuart_rx_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fr_done   (fr_done),
    .fr_mpb    (fr_mpb),
    .mp_en     (mp_en),
    .sync_mode (sync_mode),
    .rie       (rie),
    .filt_wr   (filt_wr),
    .filt_en   (filt_en),
    .clr_full  (clr_full),
    .clr_err   (clr_err),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .frm_err   (frm_err),
    .ovr_err   (ovr_err),
    .mpb_flag  (mpb_flag),
    .irq_rx    (irq_rx),
    .irq_err   (irq_err)
);

// File: tb/mpuart_rx_test.sv
// Directed bench for mpuart_rx: one task per scenario, each self-checking.
module mpuart_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT        = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick16 = 1'b0;
    logic       mp_en = 1'b0;
    logic       sync_mode = 1'b0;
    logic       rie = 1'b0;
    logic       filt_wr = 1'b0;
    logic       filt_wdata = 1'b0;
    logic       clr_full = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, frm_err, ovr_err, mpb_flag, filt_en, irq_rx, irq_err;

    int total = 0;
    int bad   = 0;
    int tdiv  = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Baud tick: one clock in TICK_DIV.
    always @(posedge clk) begin
        tdiv   <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == TICK_DIV - 1);
    end

    mpuart_rx uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16),
        .mp_en(mp_en), .sync_mode(sync_mode), .rie(rie),
        .filt_wr(filt_wr), .filt_wdata(filt_wdata),
        .clr_full(clr_full), .clr_err(clr_err),
        .rx_data(rx_data), .rx_full(rx_full), .frm_err(frm_err),
        .ovr_err(ovr_err), .mpb_flag(mpb_flag), .filt_en(filt_en),
        .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit with_flag,
                        input bit flag, input bit stop_good);
        @(negedge clk) rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (with_flag) begin
            rxd = flag;
            repeat (BIT) @(negedge clk);
        end
        if (stop_good) begin
            rxd = 1'b1;
            repeat (BIT) @(negedge clk);
        end else begin
            rxd = 1'b0;
            repeat (BIT / 2 + 8) @(negedge clk);
            rxd = 1'b1;
            repeat (BIT / 2 - 8) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic pulse_clr_full();
        @(negedge clk) clr_full = 1'b1;
        @(negedge clk) clr_full = 1'b0;
    endtask

    task automatic pulse_clr_err();
        @(negedge clk) clr_err = 1'b1;
        @(negedge clk) clr_err = 1'b0;
    endtask

    task automatic write_filt(input bit v);
        @(negedge clk) begin filt_wr = 1'b1; filt_wdata = v; end
        @(negedge clk) filt_wr = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R12 rx_data", rx_data, 0);
        chk("R12 rx_full", rx_full, 0);
        chk("R12 err", {frm_err, ovr_err}, 0);
        chk("R12 mpb_flag", mpb_flag, 0);
        chk("R6 filt_en reset", filt_en, 0);
        chk("R12 irq", {irq_rx, irq_err}, 0);
    endtask

    task automatic t_plain_frame();
        mp_en = 1'b0; rie = 1'b1;
        send(8'hA5, 1'b0, 1'b0, 1'b1);
        chk("R1 data plain", rx_data, 8'hA5);
        chk("R1 full plain", rx_full, 1);
        chk("R7 irq_rx", irq_rx, 1);
        chk("R8 no frm_err", frm_err, 0);
        pulse_clr_full();
        chk("R10 clr_full", rx_full, 0);
        chk("R7 irq_rx after clear", irq_rx, 0);
        pulse_clr_full();
        chk("R10 clr when empty full", rx_full, 0);
        chk("R10 clr when empty data", rx_data, 8'hA5);
        chk("R10 clr when empty err", {frm_err, ovr_err}, 0);
    endtask

    task automatic t_flag_frame();
        mp_en = 1'b1;
        send(8'h3C, 1'b1, 1'b0, 1'b1);
        chk("R1 data flagged", rx_data, 8'h3C);
        chk("R1 mpb_flag 0", mpb_flag, 0);
        chk("R1 full flagged", rx_full, 1);
    endtask

    task automatic t_filter();
        write_filt(1'b1);
        @(negedge clk);
        chk("R6 filt_en set", filt_en, 1);
        chk("R7 irq_rx masked", irq_rx, 0);
        pulse_clr_full();
        send(8'h55, 1'b1, 1'b0, 1'b0);
        chk("R2 data kept", rx_data, 8'h3C);
        chk("R2 full kept", rx_full, 0);
        chk("R2 no frm_err", frm_err, 0);
        chk("R2 no ovr_err", ovr_err, 0);
        chk("R2 filt_en stays", filt_en, 1);
        chk("R7 irq low in filter", {irq_rx, irq_err}, 0);
        send(8'h81, 1'b1, 1'b1, 1'b1);
        chk("R3 data id", rx_data, 8'h81);
        chk("R3 mpb_flag", mpb_flag, 1);
        chk("R3 filt_en cleared", filt_en, 0);
        chk("R3 full", rx_full, 1);
        chk("R7 irq_rx after id", irq_rx, 1);
        pulse_clr_full();
    endtask

    task automatic t_after_id();
        send(8'h12, 1'b1, 1'b0, 1'b1);
        chk("R4 data", rx_data, 8'h12);
        chk("R4 mpb_flag", mpb_flag, 0);
        chk("R4 full", rx_full, 1);
        pulse_clr_full();
    endtask

    task automatic t_sw_release();
        write_filt(1'b1);
        write_filt(1'b0);
        @(negedge clk);
        chk("R6 filt_en written 0", filt_en, 0);
        send(8'h77, 1'b1, 1'b0, 1'b1);
        chk("R6 data after release", rx_data, 8'h77);
        pulse_clr_full();
    endtask

    task automatic t_ignored();
        write_filt(1'b1);
        mp_en = 1'b0;
        send(8'h44, 1'b0, 1'b0, 1'b1);
        chk("R5 mp off data", rx_data, 8'h44);
        chk("R5 mp off full", rx_full, 1);
        pulse_clr_full();
        mp_en = 1'b1; sync_mode = 1'b1;
        send(8'h66, 1'b1, 1'b0, 1'b1);
        chk("R5 sync data", rx_data, 8'h66);
        chk("R5 sync filt_en kept", filt_en, 1);
        pulse_clr_full();
        sync_mode = 1'b0;
        write_filt(1'b0);
    endtask

    task automatic t_framing();
        mp_en = 1'b0;
        send(8'h99, 1'b0, 1'b0, 1'b0);
        chk("R8 frm_err", frm_err, 1);
        chk("R8 data", rx_data, 8'h99);
        chk("R7 irq_err", irq_err, 1);
        pulse_clr_err();
        chk("R10 clr_err", frm_err, 0);
        pulse_clr_full();
    endtask

    task automatic t_overrun();
        send(8'h21, 1'b0, 1'b0, 1'b1);
        send(8'h42, 1'b0, 1'b0, 1'b1);
        chk("R9 ovr_err", ovr_err, 1);
        chk("R9 data kept", rx_data, 8'h21);
        chk("R9 irq_err", irq_err, 1);
        pulse_clr_err();
        chk("R10 clr_err ovr", ovr_err, 0);
        pulse_clr_full();
    endtask

    task automatic t_glitch();
        @(negedge clk) rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        chk("R11 glitch ignored", rx_full, 0);
        send(8'h5A, 1'b0, 1'b0, 1'b1);
        chk("R11 data after glitch", rx_data, 8'h5A);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain_frame();
        t_flag_frame();
        t_filter();
        t_after_id();
        t_sw_release();
        t_ignored();
        t_framing();
        t_overrun();
        t_glitch();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule